// File: doc/BRIEF.md
# Counter-Addressed Test Point Access Controller

This block gives a tester access to many internal observation and control points through a handful of pins. A single address counter advances one step on each clock in which the advance pin is high. In observe mode the counter selects one of 2^ADDR_W internal monitor points. That point is placed on a working output that is shared with functional logic, so no extra output pin is needed.

In load mode the same counter acts as a demultiplexer address. The serial control bit is written into the addressed holding flip-flop, and that flip-flop keeps its value after the counter moves on. Each control point has a bypass multiplexer. In normal mode it passes the functional signal. In either test mode it passes the held value. Setting all NUM_CTL values therefore takes NUM_CTL clocks between two test vectors.

Top module: `tp_access_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the address counter is cleared to 0 and every holding flip-flop is cleared to 0.
- R2: When `mode` is 2'b00 (normal), `cp_out` equals `func_sig` and `shared_out` equals `func_out` in the same cycle.
- R3: When `mode[1]` is 1 (observe, codes 2'b10 and 2'b11), `shared_out` equals `mon_pts[addr]`, where addr is the current counter value.
- R4: In modes other than normal, a rising edge with `step` high moves the counter up by one, unless R5 or R7 applies. A rising edge with `step` low leaves the counter unchanged.
- R5: In observe mode, the counter steps from 2^ADDR_W-1 back to 0.
- R6: In load mode (2'b01), each rising edge writes `ctl_din` into the holding flip-flop selected by the current address, if that address is below NUM_CTL. All other holding flip-flops keep their values.
- R7: In load mode, a step from an address at or above NUM_CTL-1 returns the counter to 0.
- R8: In either test mode (any `mode` other than 2'b00), `cp_out` equals the holding flip-flops, with bit i taken from flip-flop i.
- R9: In normal mode the counter and the holding flip-flops keep their values whatever `step` and `ctl_din` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 normal, 01 load, 1x observe |
| step | input | 1 | Address counter advance |
| ctl_din | input | 1 | Serial control value |
| mon_pts | input | 2^ADDR_W | Internal monitor points |
| func_sig | input | NUM_CTL | Functional signals at the control points |
| func_out | input | 1 | Functional value of the shared output |
| cp_out | output | NUM_CTL | Signals delivered to the control points |
| shared_out | output | 1 | Time-shared working output |

## Verification
The outputs `cp_out` and `shared_out` are combinational from the mode, the inputs and the state. They are due in the same cycle as the inputs that drive them. A counter step or a write to a holding flip-flop becomes visible in the cycle after the rising edge that samples `step` or `ctl_din`. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge. It compares both outputs 2 ns after each falling edge. By then the inputs have settled, and the state holds all edges up to and including the last rising edge.

// File: rtl/tp_access_ctrl.sv
module tp_access_ctrl #(
  parameter int ADDR_W  = 3,
  parameter int NUM_CTL = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode,
  input  logic                     step,
  input  logic                     ctl_din,
  input  logic [(1<<ADDR_W)-1:0]   mon_pts,
  input  logic [NUM_CTL-1:0]       func_sig,
  input  logic                     func_out,
  output logic [NUM_CTL-1:0]       cp_out,
  output logic                     shared_out
);
  localparam logic [ADDR_W-1:0] CTL_LAST = ADDR_W'(NUM_CTL - 1);
  localparam logic [ADDR_W-1:0] MON_LAST = '1;

  logic [ADDR_W-1:0]  addr_q;
  logic [NUM_CTL-1:0] hold_q;
  logic [ADDR_W-1:0]  wrap_at;

  wire test_on = (mode != 2'b00);
  wire obs_on  = mode[1];
  wire load_on = (mode == 2'b01);

  assign wrap_at = obs_on ? MON_LAST : CTL_LAST;

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (test_on && step)
      addr_q <= (addr_q >= wrap_at) ? '0 : addr_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)
        hold_q[i] <= 1'b0;
      else if (load_on && addr_q == ADDR_W'(i))
        hold_q[i] <= ctl_din;
    end
  end

  assign cp_out     = test_on ? hold_q : func_sig;
  assign shared_out = obs_on ? mon_pts[addr_q] : func_out;
endmodule

// File: rtl/tp_access_chk.sv
module tp_access_chk #(
  parameter int ADDR_W  = 3,
  parameter int NUM_CTL = 6
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          mode,
  input logic                step,
  input logic                ctl_din,
  input logic [ADDR_W-1:0]   addr_q,
  input logic [NUM_CTL-1:0]  hold_q
);
  localparam logic [ADDR_W-1:0] CTL_LAST = ADDR_W'(NUM_CTL - 1);
  localparam logic [ADDR_W-1:0] MON_LAST = '1;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (addr_q == '0 && hold_q == '0)); // R1
  AST_NORMAL_HOLDS: assert property (@(posedge clk) disable iff (rst) (mode == 2'b00) |=> (addr_q == $past(addr_q) && hold_q == $past(hold_q))); // R9
  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst) (mode != 2'b00 && step && addr_q < CTL_LAST) |=> addr_q == $past(addr_q) + 1'b1); // R4
  AST_NO_STEP: assert property (@(posedge clk) disable iff (rst) !step |=> addr_q == $past(addr_q)); // R4
  AST_OBS_WRAP: assert property (@(posedge clk) disable iff (rst) (mode[1] && step && addr_q == MON_LAST) |=> addr_q == '0); // R5
  AST_LOAD_WRAP: assert property (@(posedge clk) disable iff (rst) (mode == 2'b01 && step && addr_q >= CTL_LAST) |=> addr_q == '0); // R7
  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (rst) (mode == 2'b01 && addr_q <= CTL_LAST) |=> hold_q[$past(addr_q)] == $past(ctl_din)); // R6
  AST_OBS_NO_WRITE: assert property (@(posedge clk) disable iff (rst) mode[1] |=> hold_q == $past(hold_q)); // R6
endmodule

bind tp_access_ctrl tp_access_chk #(.ADDR_W(ADDR_W), .NUM_CTL(NUM_CTL)) u_chk (.*);

// File: tb/tb_tp_access_ctrl.sv
`timescale 1ns/1ps
module tb_tp_access_ctrl;
  localparam int AW = 3;
  localparam int NC = 6;
  localparam int NM = 1 << AW;

  logic clk = 0;
  logic rst = 1;
  logic [1:0] mode = 2'b10;
  logic step = 0, ctl_din = 0, func_out = 0;
  logic [NM-1:0] mon_pts = 8'hA5;
  logic [NC-1:0] func_sig = '0;
  logic [NC-1:0] cp_out;
  logic shared_out;

  int tests = 0, fails = 0;
  bit started = 0, done = 0;
  int m_addr = 0;
  logic [NC-1:0] m_hold = '0;

  always #4 clk = ~clk;

  tp_access_ctrl #(.ADDR_W(AW), .NUM_CTL(NC)) dut (.*);

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_addr = 0; m_hold = '0;
    end else begin
      if (mode == 2'b01 && m_addr < NC) m_hold[m_addr] = ctl_din;
      if (mode != 2'b00 && step) begin
        if (m_addr >= (mode[1] ? NM - 1 : NC - 1)) m_addr = 0;
        else m_addr = m_addr + 1;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk); #2;
      if (started && !done) begin
        logic [NC-1:0] e_cp;
        logic e_sh;
        e_cp = (mode != 2'b00) ? m_hold : func_sig;
        e_sh = mode[1] ? mon_pts[m_addr] : func_out;
        tests++;
        if (cp_out !== e_cp) begin
          fails++;
          $display("FAIL %s cp_out=%b expected %b", (mode != 2'b00) ? "R8 R6 R7 R1" : "R2 R9", cp_out, e_cp);
        end
        tests++;
        if (shared_out !== e_sh) begin
          fails++;
          $display("FAIL %s shared_out=%b expected %b (addr %0d)", mode[1] ? "R3 R4 R5 R1" : "R2", shared_out, e_sh, m_addr);
        end
      end
    end
  end

  task automatic drive(input logic [1:0] m, input logic s, input logic d);
    @(negedge clk);
    mode = m; step = s; ctl_din = d;
    mon_pts = NM'($urandom); func_sig = NC'($urandom); func_out = 1'($urandom);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #6;
    // R1 explicit reset check
    tests++;
    if (cp_out !== '0 || shared_out !== mon_pts[0]) begin
      fails++;
      $display("FAIL R1 cp_out=%b shared_out=%b expected 0 and %b", cp_out, shared_out, mon_pts[0]);
    end
    @(negedge clk); rst = 0;
    for (int i = 0; i < 20; i++) drive(2'b00, 1'($urandom), 1'($urandom));   // R2 R9
    for (int i = 0; i < NC; i++) drive(2'b01, 1'b1, 1'(i % 2 == 0));           // R6
    for (int i = 0; i < 16; i++) drive(2'b01, 1'($urandom), 1'($urandom));    // R6 R7
    for (int i = 0; i < 20; i++) drive(2'b10, 1'b1, 1'($urandom));            // R3 R5
    for (int i = 0; i < 20; i++) drive(2'b11, 1'($urandom), 1'($urandom));    // R3 R4
    for (int i = 0; i < 10; i++) drive(2'b00, 1'b1, 1'($urandom));            // R9
    for (int i = 0; i < 4; i++) drive(2'b10, 1'b0, 1'b1);                     // R4
    @(negedge clk); rst = 1; mode = 2'b01; ctl_din = 1;                         // R1
    @(negedge clk); rst = 0;
    for (int i = 0; i < 300; i++) drive(2'($urandom), 1'($urandom), 1'($urandom));
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule